// File: doc/BRIEF.md
# Multi-Mode Encoder Position Counter

This block turns two encoder lines, A and B, into a 32-bit position count. Software chooses at run time how the lines are interpreted. In quadrature mode every edge of either line is a step, which gives four counts per encoder cycle. In pulse-plus-direction mode a rising edge of A is a step and B sets the direction. In up-only and down-only modes only A is used.

The count stays between zero and a programmable ceiling and wraps at both ends. Both lines are resynchronised to the system clock before edges are detected. A small synchronous register port gives access to the count, the ceiling and two 16-bit control words. Software may load the count directly, but only with a value that does not exceed the ceiling.

Top module: `enc_position_counter`

## Requirements
- R1: After reset the count reads 0, the ceiling reads 0xFFFFFFFF, and both control words read 0.
- R2: The mode is set by bits 15:14 of the decoder word at offset 0x28. Code 0 is quadrature. In quadrature mode the {A,B} steps 00→01→11→10→00 each add one to the count. The new count is visible on the read port after the third rising clock edge that follows a line change.
- R3: In quadrature mode the reverse order 00→10→11→01→00 subtracts one for each step.
- R4: In quadrature mode, a change of both lines in the same sampled cycle leaves the count unchanged.
- R5: Mode code 1 is pulse/direction. A rising edge of A adds one when B is high and subtracts one when B is low. A falling edge of A and any edge of B do not count.
- R6: Mode code 2 is up-count. Each rising edge of A adds one, and B has no effect.
- R7: Mode code 3 is down-count. Each rising edge of A subtracts one, and B has no effect.
- R8: In up-count and down-count modes, when bit 11 of the decoder word is set, both edges of A count.
- R9: Bit 3 of the control word at offset 0x2A enables counting. While it is clear, line activity leaves the count unchanged.
- R10: Counting up from a value at or above the ceiling gives 0. Counting down from 0 gives the ceiling.
- R11: A write to the count at offset 0x00 is taken only if the value does not exceed the ceiling at offset 0x08. A larger value is discarded and the old count stays.
- R12: An accepted count write that lands in the same cycle as a count step wins, and the step is dropped.
- R13: Each register reads back what was last written to it. The 16-bit words keep the low 16 bits of the write data and read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_a | input | 1 | Encoder line A, asynchronous |
| line_b | input | 1 | Encoder line B, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr`, combinational |

## Verification
The hardest case to reach is the collision in R12. A count write must arrive in exactly the cycle in which a synchronised edge produces a step, and that step surfaces only after two synchroniser stages. The bench changes line A, lets two rising edges pass so that the edge is inside the detector, and then asserts the write so that it is sampled on the third edge. The illegal quadrature transitions in R4 are reached by changing both lines in the same half-cycle, so that both synchroniser chains carry the change together.

// File: rtl/enc_pkg.sv
// Package: shared types and register offsets for the encoder position counter.
// Assumes byte addressing on the register port.
package enc_pkg;

    typedef enum logic [1:0] {
        SRC_QUAD = 2'd0,
        SRC_PDIR = 2'd1,
        SRC_UP   = 2'd2,
        SRC_DOWN = 2'd3
    } enc_src_e;

    localparam logic [7:0] OFS_COUNT = 8'h00;
    localparam logic [7:0] OFS_CEIL  = 8'h08;
    localparam logic [7:0] OFS_DEC   = 8'h28;
    localparam logic [7:0] OFS_CTRL  = 8'h2A;

    localparam int SRC_MSB   = 15;
    localparam int BOTH_BIT  = 11;
    localparam int RUN_BIT   = 3;

endpackage

// File: rtl/enc_sync.sv
// enc_sync: a two-stage synchroniser for W asynchronous inputs.
// Assumes the inputs are quasi-static relative to clk; both stages reset to 0.
module enc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    // Move the inputs through two flops into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/enc_decode.sv
// enc_decode: detects edges on the synchronised lines and turns them into a
// one-cycle step plus a direction, according to the selected source mode.
// Assumes a_s and b_s are already synchronous to clk.
module enc_decode
    import enc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     a_s,
    input  logic     b_s,
    input  enc_src_e src,
    input  logic     both_edges,
    output logic     step,
    output logic     up
);
    logic a_prev, b_prev;
    logic a_chg, b_chg, a_rise;
    logic [1:0] ph_old, ph_new, ph_delta;

    // Keep the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_prev <= 1'b0;
            b_prev <= 1'b0;
        end else begin
            a_prev <= a_s;
            b_prev <= b_s;
        end
    end

    assign a_chg  = a_s ^ a_prev;
    assign b_chg  = b_s ^ b_prev;
    assign a_rise = a_s & ~a_prev;

    // Gray position {A, A^B} gives 0,1,2,3 along the upward sequence.
    assign ph_old   = {a_prev, a_prev ^ b_prev};
    assign ph_new   = {a_s, a_s ^ b_s};
    assign ph_delta = ph_new - ph_old;

    // Choose the step and the direction for the active mode.
    always_comb begin
        step = 1'b0;
        up   = 1'b1;
        unique case (src)
            SRC_QUAD: begin
                step = (ph_delta == 2'd1) || (ph_delta == 2'd3);
                up   = (ph_delta == 2'd1);
            end
            SRC_PDIR: begin
                step = a_rise;
                up   = b_s;
            end
            SRC_UP: begin
                step = both_edges ? a_chg : a_rise;
                up   = 1'b1;
            end
            SRC_DOWN: begin
                step = both_edges ? a_chg : a_rise;
                up   = 1'b0;
            end
            default: ;
        endcase
    end

    assert_illegal_quad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_QUAD && a_chg && b_chg) |-> !step);
    assert_b_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((src == SRC_UP || src == SRC_DOWN) && !a_chg) |-> !step);
    assert_down_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_DOWN && step) |-> !up);
    assert_pdir_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_PDIR && !a_rise) |-> !step);
endmodule

// File: rtl/enc_position.sv
// enc_position: the bounded position register. An accepted software load wins
// over a step; otherwise an enabled step moves the count and wraps at 0 / ceil.
// Assumes step is a single-cycle pulse.
module enc_position #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_req,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] ceil_val,
    input  logic         run,
    input  logic         step,
    input  logic         up,
    output logic [W-1:0] cnt
);
    logic load_ok;
    assign load_ok = load_req && (load_val <= ceil_val);

    // Update the count: load first, then an enabled step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_ok) begin
            cnt <= load_val;
        end else if (run && step) begin
            if (up) cnt <= (cnt >= ceil_val) ? '0 : cnt + 1'b1;
            else    cnt <= (cnt == '0) ? ceil_val : cnt - 1'b1;
        end
    end

    assert_reject_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && load_val > ceil_val && !(run && step)) |=> $stable(cnt));
    assert_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_req && !run) |=> $stable(cnt));
    assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && load_val <= ceil_val) |=> cnt == $past(load_val));
    assert_wrap_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_req && run && step && !up && cnt == '0) |=> cnt == $past(ceil_val));
endmodule

// File: rtl/enc_position_counter.sv
// enc_position_counter: top level. Holds the ceiling and the two control words,
// decodes register writes, and joins the synchroniser, decoder and counter.
// Assumes a single-cycle write strobe; reads are combinational on addr.
module enc_position_counter
    import enc_pkg::*;
#(
    parameter int CW = 32,
    parameter int AW = 8,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_a,
    input  logic          line_b,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata
);
    localparam int PADW = CW - HW;

    logic [1:0]    lines_s;
    logic [CW-1:0] ceil_q, cnt;
    logic [HW-1:0] dec_q, ctrl_q;
    logic          step, up;
    enc_src_e      src;

    enc_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({line_a, line_b}), .dout(lines_s)
    );

    assign src = enc_src_e'(dec_q[SRC_MSB -: 2]);

    enc_decode u_dec (
        .clk(clk), .rst_n(rst_n), .a_s(lines_s[1]), .b_s(lines_s[0]),
        .src(src), .both_edges(dec_q[BOTH_BIT]), .step(step), .up(up)
    );

    enc_position #(.W(CW)) u_pos (
        .clk(clk), .rst_n(rst_n),
        .load_req(wr_en && addr == AW'(OFS_COUNT)), .load_val(wdata),
        .ceil_val(ceil_q), .run(ctrl_q[RUN_BIT]), .step(step), .up(up),
        .cnt(cnt)
    );

    // Hold the ceiling and control words written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ceil_q <= '1;
            dec_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (addr == AW'(OFS_CEIL)) ceil_q <= wdata;
            if (addr == AW'(OFS_DEC))  dec_q  <= wdata[HW-1:0];
            if (addr == AW'(OFS_CTRL)) ctrl_q <= wdata[HW-1:0];
        end
    end

    // Return the register selected by addr.
    always_comb begin
        unique case (addr)
            AW'(OFS_COUNT): rdata = cnt;
            AW'(OFS_CEIL):  rdata = ceil_q;
            AW'(OFS_DEC):   rdata = {{PADW{1'b0}}, dec_q};
            AW'(OFS_CTRL):  rdata = {{PADW{1'b0}}, ctrl_q};
            default:        rdata = '0;
        endcase
    end

    assert_ctrl_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q) && $stable(dec_q) && $stable(ceil_q));
endmodule

// File: tb/enc_position_counter_test.sv
module enc_position_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_a = 1'b0, line_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    enc_position_counter uut (
        .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Quadrature walk: {A, B, expected count}, starting at 00 with count 10.
    localparam logic [33:0] VEC [12] = '{
        {2'b01, 32'd11}, {2'b11, 32'd12}, {2'b10, 32'd13}, {2'b00, 32'd14},
        {2'b10, 32'd13}, {2'b11, 32'd12}, {2'b01, 32'd11}, {2'b00, 32'd10},
        {2'b11, 32'd10}, {2'b00, 32'd10}, {2'b01, 32'd11}, {2'b00, 32'd10}
    };

    task automatic check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s: reg %02h actual=%0h expected=%0h", tag, a, rdata, exp);
        end
        addr = 8'h00;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00;
    endtask

    task automatic lines(input logic a, input logic b);
        @(negedge clk);
        line_a = a; line_b = b;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        check("R1", 8'h00, 32'd0);
        check("R1", 8'h08, 32'hFFFF_FFFF);
        check("R1", 8'h28, 32'd0);
        check("R1", 8'h2A, 32'd0);
        // R9 disabled: quadrature activity ignored
        lines(1'b0, 1'b1);
        check("R9", 8'h00, 32'd0);
        lines(1'b0, 1'b0);
        check("R9", 8'h00, 32'd0);
        // R13 readback, R11 accept and reject
        wr(8'h08, 32'd100);
        check("R13", 8'h08, 32'd100);
        wr(8'h00, 32'd10);
        check("R11", 8'h00, 32'd10);
        wr(8'h00, 32'd101);
        check("R11", 8'h00, 32'd10);
        wr(8'h2A, 32'hABC0_0008);
        check("R13", 8'h2A, 32'h0000_0008);
        // R2 R3 R4 quadrature table
        for (int i = 0; i < 12; i++) begin
            lines(VEC[i][33], VEC[i][32]);
            check(i < 4 ? "R2" : (i < 8 ? "R3" : "R4"), 8'h00, VEC[i][31:0]);
        end
        // R10 wrap both ways
        wr(8'h00, 32'd100);
        lines(1'b0, 1'b1);
        check("R10", 8'h00, 32'd0);
        lines(1'b0, 1'b0);
        check("R10", 8'h00, 32'd100);
        // R5 pulse/direction
        wr(8'h28, 32'h0000_4000);
        check("R13", 8'h28, 32'h0000_4000);
        wr(8'h00, 32'd50);
        lines(1'b0, 1'b1);
        check("R5", 8'h00, 32'd50);
        lines(1'b1, 1'b1);
        check("R5", 8'h00, 32'd51);
        lines(1'b0, 1'b1);
        check("R5", 8'h00, 32'd51);
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        check("R5", 8'h00, 32'd50);
        // R6 up-count, rising only, B ignored
        wr(8'h28, 32'h0000_8000);
        lines(1'b0, 1'b0);
        check("R6", 8'h00, 32'd50);
        lines(1'b1, 1'b0);
        check("R6", 8'h00, 32'd51);
        lines(1'b1, 1'b1);
        check("R6", 8'h00, 32'd51);
        lines(1'b1, 1'b0);
        check("R6", 8'h00, 32'd51);
        // R8 up-count both edges
        wr(8'h28, 32'h0000_A800);
        lines(1'b0, 1'b0);
        check("R8", 8'h00, 32'd52);
        lines(1'b1, 1'b0);
        check("R8", 8'h00, 32'd53);
        // R7 down-count rising only
        wr(8'h28, 32'h0000_C000);
        lines(1'b0, 1'b1);
        check("R7", 8'h00, 32'd53);
        lines(1'b1, 1'b0);
        check("R7", 8'h00, 32'd52);
        // R8 down-count both edges
        wr(8'h28, 32'h0000_E800);
        lines(1'b0, 1'b0);
        check("R8", 8'h00, 32'd51);
        // R12 write collides with a step
        @(negedge clk);
        line_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h00; wdata = 32'd77;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R12", 8'h00, 32'd77);
        // R9 disable again
        wr(8'h2A, 32'h0000_0000);
        lines(1'b0, 1'b0);
        check("R9", 8'h00, 32'd77);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule